// File: doc/BRIEF.md
# Frame-Synchronised Window Configuration Bank

This block keeps the configuration of a multi-window display overlay engine (five windows by default). Software writes each window's control word, on-screen origin and on-screen extent into a staging copy over a simple word-addressed register bus. The display pipeline reads a separate active copy. Staging is moved into the active copy only on a vertical sync strobe, so a frame never starts with a half-written set of fields.

Each window has a hold bit in a shared hold register. While a window's hold bit is set, that window keeps its active fields at every sync strobe. Software can then rewrite several related fields, clear the bit, and the complete new set appears at the next strobe. The window's display-on bit (bit 0 of its control word) and its separate path-enable bit in a shared path register are copied in the same way, so turning a window on or off also waits for a frame boundary. Two global output-enable bits complete the bank. One acts as soon as it is written. The other is a copy that loads at sync. Output runs only when both are set.

Bus reads return staging values. A second, read-only address port returns the active value at the same address map, so the pipeline's view can be inspected.

Top module: `shadow_bank_top`

## Requirements
- R1: After a synchronous active-low reset, every staging word, active word, hold bit, path bit and output-enable bit reads 0, and all exported outputs are 0.
- R2: A bus write to a mapped address changes the staging value, which bus_rdata returns from the next cycle. The active value and every exported output derived from it stay unchanged until a vsync strobe.
- R3: Window w's registers sit at word address 4*w + slot, with slot 0 the control word, slot 1 the origin and slot 2 the extent. On a cycle with vsync high and window w's hold bit clear, that window's active words and active path bit take their staging values, and the exports show them from the next cycle.
- R4: The hold register is at address 4*NWIN+1 and bit w holds window w. While bit w is set, a vsync leaves window w's active words and active path bit unchanged. Windows whose hold bit is clear still load.
- R5: After a hold bit is cleared, window w's pending staging values stay out of the active set until the next vsync, and then all of them load together.
- R6: act_win_on[w] equals active control bit 0 AND the active path bit w. The path register is at address 4*NWIN+2. Clearing either bit in staging leaves act_win_on[w] at 1 until the next vsync, and setting them waits for a vsync in the same way.
- R7: When a bus write and vsync fall in the same cycle, staging takes the new data, and the active copy receives the value staging held before that write.
- R8: The global register is at address 4*NWIN. Bit 0 drives video_on from the cycle after the write. Bit 1 is copied to video_on_f at every vsync, whatever the hold bits. scan_active is 1 exactly when both are 1.
- R9: The hold register takes effect from the cycle after it is written. A vsync in the same cycle as a write to the hold register uses the hold bits held before that write.
- R10: view_data returns the active value at view_addr, using the bus address map. For the global word, bit 0 is video_on and bit 1 is the active copy. Slot 3 of any window and any address above 4*NWIN+2 read 0 on both ports, and writes there change nothing.
- R11: Only implemented bits are stored: control bits [CTRL_W-1:0] (8 by default); origin and extent keep X in [COORD_W-1:0] and Y in [16+COORD_W-1:16] (COORD_W 12 by default); global bits [1:0]; hold and path bits [NWIN-1:0]. Other bits read 0. Exported origin and extent are packed per window as {Y, X}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W (5) | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Staging value at bus_addr (combinational) |
| vsync | input | 1 | Frame boundary strobe; staging-to-active transfer on each high cycle |
| view_addr | input | ADDR_W (5) | Address for the active-value view |
| view_data | output | 32 | Active value at view_addr (combinational) |
| act_win_ctrl | output | NWIN*CTRL_W | Active control words, window 0 in the low bits |
| act_win_origin | output | NWIN*2*COORD_W | Active origin per window, {Y, X} |
| act_win_extent | output | NWIN*2*COORD_W | Active extent per window, {Y, X} |
| act_win_on | output | NWIN | Window shown: active control bit 0 AND active path bit |
| act_chan_en | output | NWIN | Active path-enable bits |
| video_on | output | 1 | Immediate global output enable |
| video_on_f | output | 1 | Frame-latched global output enable |
| scan_active | output | 1 | Both global enables set |

## Verification
The assertions check, on every cycle, that active words, path bits, the latched output enable and act_win_on do not move without a vsync strobe. They also check that a held window keeps its active state through a strobe, that an unheld window loads exactly the staging value of the cycle before, and that one bus write reaches at most one register. Orderings that span several writes and strobes are shown only by the bench's scenarios. These cover a hold released with updates pending, a write or hold change in the same cycle as vsync, a disable that lingers until the frame edge, and unmapped writes that leave the register state unchanged. The bench's reference model also compares both read ports and every export on each clock during a long random run.

// File: rtl/shadow_bank_pkg.sv
// Shared definitions for the frame-synchronised window configuration bank.
// Assumes 32-bit register words and field widths below 16 bits per half.
package shadow_bank_pkg;

    localparam int WORD_W     = 32;
    localparam int HALF_SHIFT = 16;

    // Register slot inside one window's four-word group.
    typedef enum logic [1:0] {
        SLOT_CTRL   = 2'd0,
        SLOT_ORIGIN = 2'd1,
        SLOT_EXTENT = 2'd2,
        SLOT_NONE   = 2'd3
    } win_slot_e;

    // Offsets of the shared registers above the window groups.
    localparam int SHR_GLOBAL  = 0;
    localparam int SHR_HOLD    = 1;
    localparam int SHR_PATH    = 2;
    localparam int SHR_COUNT   = 3;

    // Mask of the low n bits of a word.
    function automatic logic [WORD_W-1:0] low_mask(input int n);
        return (WORD_W'(1) << n) - WORD_W'(1);
    endfunction

    // Mask of an X/Y pair, X in the low half and Y in the high half.
    function automatic logic [WORD_W-1:0] pair_mask(input int n);
        logic [WORD_W-1:0] m;
        m = low_mask(n);
        return m | (m << HALF_SHIFT);
    endfunction

endpackage

// File: rtl/shadow_addr_decode.sv
// Address decoder: turns one bus write into at most one register strobe.
// Assumes windows occupy 4-word groups from address 0 and the three
// shared registers follow directly after the last group.
module shadow_addr_decode
    import shadow_bank_pkg::*;
#(
    parameter int NWIN   = 5,
    parameter int ADDR_W = 5
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NWIN-1:0]   win_we,
    output win_slot_e         win_slot,
    output logic              glb_we,
    output logic              hold_we,
    output logic              path_we
);

    localparam int IDX_W    = ADDR_W - 2;
    localparam int SHR_BASE = NWIN * 4;

    // Slot field taken straight from the two low address bits.
    assign win_slot = win_slot_e'(bus_addr[1:0]);

    // One write strobe per window group, slot 3 left unmapped.
    always_comb begin
        win_we = '0;
        for (int w = 0; w < NWIN; w++) begin
            if (bus_we && (bus_addr[ADDR_W-1:2] == IDX_W'(w)) &&
                (bus_addr[1:0] != 2'd3)) begin
                win_we[w] = 1'b1;
            end
        end
    end

    // Strobes for the shared registers.
    assign glb_we  = bus_we && (bus_addr == ADDR_W'(SHR_BASE + SHR_GLOBAL));
    assign hold_we = bus_we && (bus_addr == ADDR_W'(SHR_BASE + SHR_HOLD));
    assign path_we = bus_we && (bus_addr == ADDR_W'(SHR_BASE + SHR_PATH));

endmodule

// File: rtl/shadow_win_regs.sv
// One window's staging and active register words (control, origin, extent).
// Staging follows bus writes; active copies staging on a vsync cycle when
// the window's hold bit is clear. Assumes at most one slot written a cycle.
module shadow_win_regs
    import shadow_bank_pkg::*;
#(
    parameter int CTRL_W  = 8,
    parameter int COORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  win_slot_e         wr_slot,
    input  logic [WORD_W-1:0] wdata,
    input  logic              vsync,
    input  logic              hold,
    output logic [WORD_W-1:0] stg_ctrl,
    output logic [WORD_W-1:0] stg_origin,
    output logic [WORD_W-1:0] stg_extent,
    output logic [WORD_W-1:0] act_ctrl,
    output logic [WORD_W-1:0] act_origin,
    output logic [WORD_W-1:0] act_extent
);

    localparam logic [WORD_W-1:0] CTRL_MASK = low_mask(CTRL_W);
    localparam logic [WORD_W-1:0] PAIR_MASK = pair_mask(COORD_W);

    // Staging words: bus writes, masked to implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_ctrl   <= '0;
            stg_origin <= '0;
            stg_extent <= '0;
        end else if (wr_en) begin
            case (wr_slot)
                SLOT_CTRL:   stg_ctrl   <= wdata & CTRL_MASK;
                SLOT_ORIGIN: stg_origin <= wdata & PAIR_MASK;
                SLOT_EXTENT: stg_extent <= wdata & PAIR_MASK;
                default:     ;
            endcase
        end
    end

    // Active words: frame-boundary transfer unless the window is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_ctrl   <= '0;
            act_origin <= '0;
            act_extent <= '0;
        end else if (vsync && !hold) begin
            act_ctrl   <= stg_ctrl;
            act_origin <= stg_origin;
            act_extent <= stg_extent;
        end
    end

    AST_ACT_HOLD_NO_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> $stable({act_ctrl, act_origin, act_extent})); // R2

    AST_ACT_HOLD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && hold) |=> $stable({act_ctrl, act_origin, act_extent})); // R4

    AST_ACT_LOAD_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && !hold) |=> ({act_ctrl, act_origin, act_extent} ==
                              $past({stg_ctrl, stg_origin, stg_extent}))); // R7

endmodule

// File: rtl/shadow_shared_regs.sv
// Shared registers: global output enables, per-window hold bits and
// per-window path-enable bits with their frame-latched copies.
// Assumes NWIN >= 2 so the global bits fit in the write-bit slice.
module shadow_shared_regs #(
    parameter int NWIN = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            glb_we,
    input  logic            hold_we,
    input  logic            path_we,
    input  logic [NWIN-1:0] wbits,
    input  logic            vsync,
    output logic            video_on,
    output logic            video_on_stg,
    output logic            video_on_act,
    output logic [NWIN-1:0] hold,
    output logic [NWIN-1:0] path_stg,
    output logic [NWIN-1:0] path_act
);

    // Global enables: bit 0 immediate, bit 1 staged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            video_on     <= 1'b0;
            video_on_stg <= 1'b0;
        end else if (glb_we) begin
            video_on     <= wbits[0];
            video_on_stg <= wbits[1];
        end
    end

    // Frame-latched global enable, never held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            video_on_act <= 1'b0;
        end else if (vsync) begin
            video_on_act <= video_on_stg;
        end
    end

    // Hold bits act immediately.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (hold_we) begin
            hold <= wbits;
        end
    end

    // Path-enable staging bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            path_stg <= '0;
        end else if (path_we) begin
            path_stg <= wbits;
        end
    end

    // Per-window path transfer, gated by that window's hold bit.
    for (genvar w = 0; w < NWIN; w++) begin : g_path
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                path_act[w] <= 1'b0;
            end else if (vsync && !hold[w]) begin
                path_act[w] <= path_stg[w];
            end
        end

        AST_PATH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (vsync && hold[w]) |=> $stable(path_act[w])); // R4
    end

    AST_VIDF_NO_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> $stable(video_on_act)); // R8

    AST_VIDF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> (video_on_act == $past(video_on_stg))); // R8

    AST_HOLD_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_we |=> (hold == $past(wbits))); // R9

endmodule

// File: rtl/shadow_read_mux.sv
// Read multiplexer over one register set (staging or active).
// Unmapped addresses and window slot 3 return zero.
module shadow_read_mux
    import shadow_bank_pkg::*;
#(
    parameter int NWIN   = 5,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] ctrl_w   [NWIN],
    input  logic [WORD_W-1:0] origin_w [NWIN],
    input  logic [WORD_W-1:0] extent_w [NWIN],
    input  logic [WORD_W-1:0] glb_w,
    input  logic [WORD_W-1:0] hold_w,
    input  logic [WORD_W-1:0] path_w,
    output logic [WORD_W-1:0] data
);

    localparam int IDX_W    = ADDR_W - 2;
    localparam int SHR_BASE = NWIN * 4;

    // Select the addressed word, zero elsewhere.
    always_comb begin
        data = '0;
        for (int w = 0; w < NWIN; w++) begin
            if (addr[ADDR_W-1:2] == IDX_W'(w)) begin
                case (win_slot_e'(addr[1:0]))
                    SLOT_CTRL:   data = ctrl_w[w];
                    SLOT_ORIGIN: data = origin_w[w];
                    SLOT_EXTENT: data = extent_w[w];
                    default:     data = '0;
                endcase
            end
        end
        if (addr == ADDR_W'(SHR_BASE + SHR_GLOBAL)) data = glb_w;
        if (addr == ADDR_W'(SHR_BASE + SHR_HOLD))   data = hold_w;
        if (addr == ADDR_W'(SHR_BASE + SHR_PATH))   data = path_w;
    end

endmodule

// File: rtl/shadow_bank_top.sv
// Frame-synchronised configuration bank for a multi-window overlay engine.
// Bus writes land in staging; vsync moves staging to the active set for
// every window whose hold bit is clear. Assumes vsync is a strobe sampled
// each cycle and a single-word bus with combinational read.
module shadow_bank_top
    import shadow_bank_pkg::*;
#(
    parameter int NWIN    = 5,
    parameter int CTRL_W  = 8,
    parameter int COORD_W = 12,
    localparam int ADDR_W = $clog2(NWIN * 4 + SHR_COUNT),
    localparam int PAIR_W = 2 * COORD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic [WORD_W-1:0]        bus_rdata,
    input  logic                     vsync,
    input  logic [ADDR_W-1:0]        view_addr,
    output logic [WORD_W-1:0]        view_data,
    output logic [NWIN*CTRL_W-1:0]   act_win_ctrl,
    output logic [NWIN*PAIR_W-1:0]   act_win_origin,
    output logic [NWIN*PAIR_W-1:0]   act_win_extent,
    output logic [NWIN-1:0]          act_win_on,
    output logic [NWIN-1:0]          act_chan_en,
    output logic                     video_on,
    output logic                     video_on_f,
    output logic                     scan_active
);

    logic [NWIN-1:0]   win_we;
    win_slot_e         win_slot;
    logic              glb_we;
    logic              hold_we;
    logic              path_we;

    logic [WORD_W-1:0] stg_ctrl   [NWIN];
    logic [WORD_W-1:0] stg_origin [NWIN];
    logic [WORD_W-1:0] stg_extent [NWIN];
    logic [WORD_W-1:0] act_ctrl   [NWIN];
    logic [WORD_W-1:0] act_origin [NWIN];
    logic [WORD_W-1:0] act_extent [NWIN];

    logic              video_on_stg;
    logic [NWIN-1:0]   hold;
    logic [NWIN-1:0]   path_stg;
    logic [NWIN-1:0]   path_act;

    logic [WORD_W-1:0] glb_stg_word;
    logic [WORD_W-1:0] glb_act_word;
    logic [WORD_W-1:0] hold_word;
    logic [WORD_W-1:0] path_stg_word;
    logic [WORD_W-1:0] path_act_word;

    shadow_addr_decode #(
        .NWIN   (NWIN),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .win_we   (win_we),
        .win_slot (win_slot),
        .glb_we   (glb_we),
        .hold_we  (hold_we),
        .path_we  (path_we)
    );

    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({win_we, glb_we, hold_we, path_we})); // R10

    AST_UNMAPPED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= ADDR_W'(NWIN * 4 + SHR_COUNT)) |->
        ({win_we, glb_we, hold_we, path_we} == '0)); // R10

    // Per-window register groups and their exported active fields.
    for (genvar w = 0; w < NWIN; w++) begin : g_win
        shadow_win_regs #(
            .CTRL_W  (CTRL_W),
            .COORD_W (COORD_W)
        ) u_win (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (win_we[w]),
            .wr_slot    (win_slot),
            .wdata      (bus_wdata),
            .vsync      (vsync),
            .hold       (hold[w]),
            .stg_ctrl   (stg_ctrl[w]),
            .stg_origin (stg_origin[w]),
            .stg_extent (stg_extent[w]),
            .act_ctrl   (act_ctrl[w]),
            .act_origin (act_origin[w]),
            .act_extent (act_extent[w])
        );

        assign act_win_ctrl[w*CTRL_W +: CTRL_W] = act_ctrl[w][CTRL_W-1:0];
        assign act_win_origin[w*PAIR_W +: PAIR_W] =
            {act_origin[w][HALF_SHIFT +: COORD_W], act_origin[w][COORD_W-1:0]};
        assign act_win_extent[w*PAIR_W +: PAIR_W] =
            {act_extent[w][HALF_SHIFT +: COORD_W], act_extent[w][COORD_W-1:0]};
        assign act_win_on[w] = act_ctrl[w][0] & path_act[w];
    end

    shadow_shared_regs #(
        .NWIN (NWIN)
    ) u_shared (
        .clk          (clk),
        .rst_n        (rst_n),
        .glb_we       (glb_we),
        .hold_we      (hold_we),
        .path_we      (path_we),
        .wbits        (bus_wdata[NWIN-1:0]),
        .vsync        (vsync),
        .video_on     (video_on),
        .video_on_stg (video_on_stg),
        .video_on_act (video_on_f),
        .hold         (hold),
        .path_stg     (path_stg),
        .path_act     (path_act)
    );

    // Shared words as seen on each read port.
    assign glb_stg_word  = {{(WORD_W-2){1'b0}}, video_on_stg, video_on};
    assign glb_act_word  = {{(WORD_W-2){1'b0}}, video_on_f, video_on};
    assign hold_word     = WORD_W'(hold);
    assign path_stg_word = WORD_W'(path_stg);
    assign path_act_word = WORD_W'(path_act);

    assign act_chan_en = path_act;
    assign scan_active = video_on & video_on_f;

    AST_WIN_ON_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> $stable(act_win_on)); // R6

    shadow_read_mux #(
        .NWIN   (NWIN),
        .ADDR_W (ADDR_W)
    ) u_bus_read (
        .addr     (bus_addr),
        .ctrl_w   (stg_ctrl),
        .origin_w (stg_origin),
        .extent_w (stg_extent),
        .glb_w    (glb_stg_word),
        .hold_w   (hold_word),
        .path_w   (path_stg_word),
        .data     (bus_rdata)
    );

    shadow_read_mux #(
        .NWIN   (NWIN),
        .ADDR_W (ADDR_W)
    ) u_view_read (
        .addr     (view_addr),
        .ctrl_w   (act_ctrl),
        .origin_w (act_origin),
        .extent_w (act_extent),
        .glb_w    (glb_act_word),
        .hold_w   (hold_word),
        .path_w   (path_act_word),
        .data     (view_data)
    );

endmodule

// File: tb/shadow_bank_top_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus
// directed scenarios per requirement and a random phase.
module shadow_bank_top_tb_top;

    localparam int NW = 5;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         bus_we;
    logic [4:0]   bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic         vsync;
    logic [4:0]   view_addr;
    logic [31:0]  view_data;
    logic [39:0]  act_win_ctrl;
    logic [119:0] act_win_origin;
    logic [119:0] act_win_extent;
    logic [4:0]   act_win_on;
    logic [4:0]   act_chan_en;
    logic         video_on;
    logic         video_on_f;
    logic         scan_active;

    int total = 0;
    int bad   = 0;

    // Reference model state.
    logic [31:0] m_stg [NW][3];
    logic [31:0] m_act [NW][3];
    logic [4:0]  m_hold, m_ps, m_pa;
    logic        m_von, m_vfs, m_vfa;

    always #5 clk = ~clk;

    shadow_bank_top dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_we         (bus_we),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .vsync          (vsync),
        .view_addr      (view_addr),
        .view_data      (view_data),
        .act_win_ctrl   (act_win_ctrl),
        .act_win_origin (act_win_origin),
        .act_win_extent (act_win_extent),
        .act_win_on     (act_win_on),
        .act_chan_en    (act_chan_en),
        .video_on       (video_on),
        .video_on_f     (video_on_f),
        .scan_active    (scan_active)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] got, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_write(input logic [4:0] a, input logic [31:0] d);
        int w, r;
        if (a < 5'd20) begin
            w = int'(a) / 4;
            r = int'(a) % 4;
            if (r == 0) m_stg[w][0] = d & 32'h0000_00FF;
            else if (r < 3) m_stg[w][r] = d & 32'h0FFF_0FFF;
        end else if (a == 5'd20) begin
            m_von = d[0];
            m_vfs = d[1];
        end else if (a == 5'd21) begin
            m_hold = d[4:0];
        end else if (a == 5'd22) begin
            m_ps = d[4:0];
        end
    endtask

    // Model advances on each rising edge with the inputs set at the prior falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NW; w++)
                for (int r = 0; r < 3; r++) begin
                    m_stg[w][r] = '0;
                    m_act[w][r] = '0;
                end
            m_hold = '0; m_ps = '0; m_pa = '0;
            m_von = 1'b0; m_vfs = 1'b0; m_vfa = 1'b0;
        end else begin
            if (vsync) begin
                for (int w = 0; w < NW; w++)
                    if (!m_hold[w]) begin
                        for (int r = 0; r < 3; r++) m_act[w][r] = m_stg[w][r];
                        m_pa[w] = m_ps[w];
                    end
                m_vfa = m_vfs;
            end
            if (bus_we) model_write(bus_addr, bus_wdata);
        end
    end

    function automatic logic [31:0] mrd(input logic [4:0] a, input bit act);
        int w, r;
        if (a < 5'd20) begin
            w = int'(a) / 4;
            r = int'(a) % 4;
            if (r == 3) return 32'h0;
            return act ? m_act[w][r] : m_stg[w][r];
        end
        if (a == 5'd20) return {30'h0, (act ? m_vfa : m_vfs), m_von};
        if (a == 5'd21) return {27'h0, m_hold};
        if (a == 5'd22) return {27'h0, (act ? m_pa : m_ps)};
        return 32'h0;
    endfunction

    task automatic compare_all();
        logic [23:0] eo, ee;
        for (int w = 0; w < NW; w++) begin
            chk(act_win_ctrl[w*8 +: 8] == m_act[w][0][7:0], "R3 ctrl",
                act_win_ctrl[w*8 +: 8], m_act[w][0][7:0]);
            eo = {m_act[w][1][27:16], m_act[w][1][11:0]};
            ee = {m_act[w][2][27:16], m_act[w][2][11:0]};
            chk(act_win_origin[w*24 +: 24] == eo, "R11 origin", act_win_origin[w*24 +: 24], eo);
            chk(act_win_extent[w*24 +: 24] == ee, "R11 extent", act_win_extent[w*24 +: 24], ee);
            chk(act_win_on[w] == (m_act[w][0][0] & m_pa[w]), "R6 win_on",
                act_win_on[w], m_act[w][0][0] & m_pa[w]);
        end
        chk(act_chan_en == m_pa, "R4 path", act_chan_en, m_pa);
        chk(video_on == m_von, "R8 video_on", video_on, m_von);
        chk(video_on_f == m_vfa, "R8 video_on_f", video_on_f, m_vfa);
        chk(scan_active == (m_von & m_vfa), "R8 scan", scan_active, m_von & m_vfa);
        chk(bus_rdata == mrd(bus_addr, 1'b0), "R2 rdata", bus_rdata, mrd(bus_addr, 1'b0));
        chk(view_data == mrd(view_addr, 1'b1), "R10 view", view_data, mrd(view_addr, 1'b1));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic vs();
        vsync = 1'b1;
        tick();
        vsync = 1'b0;
    endtask

    task automatic wr_vs(input logic [4:0] a, input logic [31:0] d);
        vsync = 1'b1;
        wr(a, d);
        vsync = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic view_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        view_addr = a;
        #1;
        chk(view_data == exp, tag, view_data, exp);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        vsync = 1'b0; view_addr = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk({act_win_ctrl, act_win_on, act_chan_en, video_on, video_on_f, scan_active} == '0,
            "R1 outputs", {act_win_ctrl, act_win_on}, 0);
        chk(act_win_origin == '0 && act_win_extent == '0, "R1 geometry", act_win_origin, 0);
        rd_chk(5'd21, 32'h0, "R1 hold");
        rd_chk(5'd0, 32'h0, "R1 ctrl0");

        // R2 / R11: staging written, active untouched
        wr(5'd0, 32'hFFFF_FFA5);
        rd_chk(5'd0, 32'h0000_00A5, "R11 ctrl mask");
        chk(act_win_ctrl[7:0] == 8'h00, "R2 active unchanged", act_win_ctrl[7:0], 0);
        wr(5'd1, 32'h0123_0456);
        wr(5'd2, 32'hF0A0_F0B0);
        rd_chk(5'd2, 32'h00A0_00B0, "R11 extent mask");
        view_chk(5'd1, 32'h0, "R10 view before vsync");

        // R3: load at vsync
        vs();
        chk(act_win_ctrl[7:0] == 8'hA5, "R3 ctrl loaded", act_win_ctrl[7:0], 8'hA5);
        chk(act_win_origin[23:0] == 24'h123456, "R11 origin packing", act_win_origin[23:0], 24'h123456);
        chk(act_win_extent[23:0] == 24'h0A00B0, "R11 extent packing", act_win_extent[23:0], 24'h0A00B0);
        chk(act_win_on[0] == 1'b0, "R6 path still off", act_win_on[0], 0);
        wr(5'd22, 32'h1);
        chk(act_win_on[0] == 1'b0, "R6 enable waits", act_win_on[0], 0);
        vs();
        chk(act_win_on[0] == 1'b1, "R3 window on", act_win_on[0], 1);

        // R4 / R5: hold windows 1 and 3
        wr(5'd21, 32'h0000_000A);
        wr(5'd4, 32'h11);
        wr(5'd8, 32'h22);
        wr(5'd12, 32'h33);
        vs();
        chk(act_win_ctrl[15:8] == 8'h00, "R4 win1 held", act_win_ctrl[15:8], 0);
        chk(act_win_ctrl[23:16] == 8'h22, "R4 win2 loads", act_win_ctrl[23:16], 8'h22);
        chk(act_win_ctrl[31:24] == 8'h00, "R4 win3 held", act_win_ctrl[31:24], 0);
        wr(5'd21, 32'h0000_0008);
        tick();
        chk(act_win_ctrl[15:8] == 8'h00, "R5 no load before vsync", act_win_ctrl[15:8], 0);
        vs();
        chk(act_win_ctrl[15:8] == 8'h11, "R5 pending applied", act_win_ctrl[15:8], 8'h11);
        chk(act_win_ctrl[31:24] == 8'h00, "R4 win3 still held", act_win_ctrl[31:24], 0);

        // R6: disables wait for the frame edge
        wr(5'd0, 32'hA4);
        chk(act_win_on[0] == 1'b1, "R6 ctrl disable deferred", act_win_on[0], 1);
        vs();
        chk(act_win_on[0] == 1'b0, "R6 ctrl disable applied", act_win_on[0], 0);
        wr(5'd0, 32'hA5);
        vs();
        wr(5'd22, 32'h0);
        chk(act_win_on[0] == 1'b1, "R6 path disable deferred", act_win_on[0], 1);
        vs();
        chk(act_win_on[0] == 1'b0, "R6 path disable applied", act_win_on[0], 0);
        wr(5'd22, 32'h1F);
        vs();

        // R7: write and vsync together
        wr(5'd16, 32'h44);
        vs();
        wr_vs(5'd16, 32'h55);
        chk(act_win_ctrl[39:32] == 8'h44, "R7 active gets prior", act_win_ctrl[39:32], 8'h44);
        rd_chk(5'd16, 32'h55, "R7 staging gets new");
        vs();
        chk(act_win_ctrl[39:32] == 8'h55, "R7 next vsync", act_win_ctrl[39:32], 8'h55);

        // R8: global enables
        wr(5'd20, 32'h1);
        chk(video_on && !video_on_f && !scan_active, "R8 immediate bit",
            {video_on, video_on_f, scan_active}, 3'b100);
        wr(5'd20, 32'h3);
        chk(!video_on_f, "R8 latched waits", video_on_f, 0);
        vs();
        chk(video_on_f && scan_active, "R8 latched at vsync", {video_on_f, scan_active}, 2'b11);
        wr(5'd20, 32'h2);
        chk(!video_on && video_on_f && !scan_active, "R8 immediate off",
            {video_on, video_on_f, scan_active}, 3'b010);
        wr(5'd20, 32'h0);
        vs();
        chk(!video_on_f, "R8 latched off", video_on_f, 0);

        // R9: hold write in the vsync cycle uses prior hold bits
        wr(5'd8, 32'h66);
        wr_vs(5'd21, 32'h0000_000C);
        chk(act_win_ctrl[23:16] == 8'h66, "R9 prior hold clear", act_win_ctrl[23:16], 8'h66);
        wr(5'd8, 32'h77);
        vs();
        chk(act_win_ctrl[23:16] == 8'h66, "R9 hold now active", act_win_ctrl[23:16], 8'h66);
        wr_vs(5'd21, 32'h0);
        chk(act_win_ctrl[23:16] == 8'h66, "R9 prior hold set", act_win_ctrl[23:16], 8'h66);
        chk(act_win_ctrl[31:24] == 8'h00, "R9 win3 prior hold", act_win_ctrl[31:24], 0);
        vs();
        chk(act_win_ctrl[23:16] == 8'h77, "R5 win2 after release", act_win_ctrl[23:16], 8'h77);
        chk(act_win_ctrl[31:24] == 8'h33, "R5 win3 after release", act_win_ctrl[31:24], 8'h33);

        // R10 / R11: unmapped addresses, view port
        wr(5'd3, 32'hFFFF_FFFF);
        wr(5'd23, 32'hFFFF_FFFF);
        wr(5'd31, 32'hFFFF_FFFF);
        rd_chk(5'd3, 32'h0, "R10 slot3 reads 0");
        rd_chk(5'd23, 32'h0, "R10 unmapped reads 0");
        rd_chk(5'd0, 32'hA5, "R10 no side effect ctrl0");
        rd_chk(5'd21, 32'h0, "R10 no side effect hold");
        vs();
        view_chk(5'd1, 32'h0123_0456, "R10 view origin");
        wr(5'd8, 32'h99);
        view_chk(5'd8, 32'h77, "R10 view is active");
        rd_chk(5'd8, 32'h99, "R10 bus is staging");
        vs();
        view_chk(5'd8, 32'h99, "R10 view after vsync");
        wr(5'd20, 32'hFFFF_FFFF);
        rd_chk(5'd20, 32'h3, "R11 global mask");
        wr(5'd21, 32'hFFFF_FFFF);
        rd_chk(5'd21, 32'h1F, "R11 hold mask");
        wr(5'd21, 32'h0);

        // Random phase, model compared on every clock.
        for (int i = 0; i < 600; i++) begin
            bus_we    = ($urandom % 2) == 0;
            bus_addr  = 5'($urandom % 32);
            bus_wdata = $urandom;
            vsync     = ($urandom % 4) == 0;
            view_addr = 5'($urandom % 32);
            tick();
        end
        bus_we = 1'b0; vsync = 1'b0;

        // R1: reset in mid-run
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        chk({act_win_ctrl, act_chan_en, video_on, video_on_f} == '0, "R1 re-reset",
            act_win_ctrl, 0);
        rd_chk(5'd22, 32'h0, "R1 path after reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule